// File: doc/BRIEF.md
# Three-Wire Control Word Loader

This block receives control settings over a slow three-line serial port (bit clock, data, active-low enable) and holds them in two banks of latched fields. While enable is low, each rising edge of the bit clock pushes one data bit into a 24-bit shift register, most significant bit first. When enable returns high, the bit that arrived last acts as a bank address. Address 0 loads the channel bank, which holds the synthesizer and modulation settings. Address 1 loads the trim bank, which holds output power, the tuning DAC code, the compensation scale and the test selector. The bank that is not addressed keeps its contents.

The three bus lines are asynchronous to the system clock. Each line passes through a synchronizer chain and its edges are detected in the system clock domain. The shift register keeps only the latest 24 bits. Extra leading bits therefore fall off the top, and the number of bit clocks in a transfer is never counted. A transfer with fewer than 24 bit clocks still loads, using whatever the shift register holds at that moment. A retain input chooses whether reset clears the latched fields or keeps them through standby.

Top module: `serial_ctl_port`

## Requirements
- R1: Bits enter the shift register MSB first, one on each synchronized rising edge of `bus_clk` while `bus_en_n` is low. Rising edges of `bus_clk` while `bus_en_n` is high shift nothing.
- R2: On a load, shift-register bit 0 (the last bit received) selects the bank: 0 loads the channel bank, 1 loads the trim bank. The other bank's outputs do not change.
- R3: The outputs change only in the single system cycle after a synchronized rising edge of `bus_en_n`. They do not change while a transfer is in progress.
- R4: When more than 24 bit clocks arrive in one transfer, only the last 24 bits are used and the earlier ones are dropped.
- R5: A transfer with fewer than 24 bit clocks still loads. The frame is the low 24 shift-register bits, which include bits left over from earlier transfers (all zero after reset).
- R6: Channel bank layout, where frame bit k+1 carries data bit dk: d22..d21 `ref_div_sel`, d20..d16 `swallow_cnt`, d15..d13 `main_cnt`, d12 `vco_tx_sel` (1 selects the transmit oscillator), d11 is ignored, d10 `comp_en`, d9..d7 `dev_scale`, d6..d3 `vco_trim`, d2..d1 `cp_step`, d0 `gauss_en`.
- R7: Trim bank layout (frame bit k+1 carries dk): d12..d11 `pa_level` (00 lowest, 11 highest power), d10..d6 `aux_dac`, d5..d3 `comp_scale`, d2..d0 `test_sel`. Bits d22..d13 are ignored.
- R8: A synchronous reset (`rst_n` low) with `retain` low clears every field to zero. With `retain` high, every field keeps its value. In both cases the shift register clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| retain | input | 1 | Keep latched fields through reset |
| bus_clk | input | 1 | Serial bit clock (asynchronous) |
| bus_dat | input | 1 | Serial data (asynchronous) |
| bus_en_n | input | 1 | Serial enable, active low (asynchronous) |
| ref_div_sel | output | 2 | Reference divider select |
| swallow_cnt | output | 5 | Swallow counter value |
| main_cnt | output | 3 | Main counter value |
| vco_tx_sel | output | 1 | Oscillator select, 1 = transmit |
| comp_en | output | 1 | Modulation compensation enable |
| dev_scale | output | 3 | Frequency deviation scale |
| vco_trim | output | 4 | Oscillator pretune code |
| cp_step | output | 2 | Charge-pump current step |
| gauss_en | output | 1 | Gaussian data filter enable |
| pa_level | output | 2 | Output power level |
| aux_dac | output | 5 | Demodulator or ramp DAC code |
| comp_scale | output | 3 | Compensation current scale |
| test_sel | output | 3 | Test output selector |

## Verification
The bound checker watches every cycle for three things: the banks stay unchanged outside a load strobe, only the addressed bank takes new data, and loaded fields match the frame bit positions of the cycle before. It also checks that two load strobes never come back to back. Only the bench scenarios can show the behaviour seen from the bus side: MSB-first ordering, dropped leading bits on long transfers, short transfers reusing leftover bits, bit clocks being ignored while enable is high, and the two reset behaviours selected by `retain`.

// File: rtl/scp_pkg.sv
package scp_pkg;

   localparam int FRAME_W = 24;

   typedef struct packed {
      logic [1:0] ref_div_sel;
      logic [4:0] swallow_cnt;
      logic [2:0] main_cnt;
      logic       vco_tx_sel;
      logic       comp_en;
      logic [2:0] dev_scale;
      logic [3:0] vco_trim;
      logic [1:0] cp_step;
      logic       gauss_en;
   } chan_word_t;

   typedef struct packed {
      logic [1:0] pa_level;
      logic [4:0] aux_dac;
      logic [2:0] comp_scale;
      logic [2:0] test_sel;
   } trim_word_t;

   localparam int CHAN_W = $bits(chan_word_t);
   localparam int TRIM_W = $bits(trim_word_t);

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
   parameter int             WIDTH   = 3,
   parameter int             STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES == 1) begin : g_bad_depth
      $error("scp_sync: STAGES must be 0 (bypass) or at least 2");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] stg [STAGES];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end

      assign q = stg[STAGES-1];
   end

endmodule

// File: rtl/scp_shift.sv
module scp_shift #(
   parameter int WIDTH = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bclk_s,
   input  logic             bdat_s,
   input  logic             ben_n_s,
   output logic [WIDTH-1:0] frame,
   output logic             load_stb
);

   if (WIDTH < 2) begin : g_bad_width
      $error("scp_shift: WIDTH must hold data and an address bit");
   end

   logic bclk_q;
   logic ben_q;
   logic bclk_rise;

   assign bclk_rise = bclk_s & ~bclk_q;
   assign load_stb  = ben_n_s & ~ben_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bclk_q <= 1'b0;
         ben_q  <= 1'b1;
         frame  <= '0;
      end else begin
         bclk_q <= bclk_s;
         ben_q  <= ben_n_s;
         if (bclk_rise && !ben_n_s) frame <= {frame[WIDTH-2:0], bdat_s};
      end
   end

endmodule

// File: rtl/scp_bank.sv
module scp_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         retain,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("scp_bank: W must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         if (!retain) q <= '0;
      end else if (load) begin
         q <= d;
      end
   end

endmodule

// File: rtl/serial_ctl_port.sv
module serial_ctl_port
   import scp_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       retain,
   input  logic       bus_clk,
   input  logic       bus_dat,
   input  logic       bus_en_n,
   output logic [1:0] ref_div_sel,
   output logic [4:0] swallow_cnt,
   output logic [2:0] main_cnt,
   output logic       vco_tx_sel,
   output logic       comp_en,
   output logic [2:0] dev_scale,
   output logic [3:0] vco_trim,
   output logic [1:0] cp_step,
   output logic       gauss_en,
   output logic [1:0] pa_level,
   output logic [4:0] aux_dac,
   output logic [2:0] comp_scale,
   output logic [2:0] test_sel
);

   localparam int ADDR_POS  = 0;
   localparam int SPARE_POS = 12;

   if (FRAME_W != CHAN_W + 2) begin : g_bad_chan
      $error("serial_ctl_port: channel layout does not fill the frame");
   end
   if (TRIM_W > FRAME_W - 1) begin : g_bad_trim
      $error("serial_ctl_port: trim layout exceeds the frame");
   end

   logic [2:0]         bus_s;
   logic [FRAME_W-1:0] frame;
   logic               load_stb;
   logic               load_chan;
   logic               load_trim;
   chan_word_t         chan_d, chan_q;
   trim_word_t         trim_d, trim_q;
   logic               unused_spare;

   scp_sync #(
      .WIDTH  (3),
      .STAGES (SYNC_STAGES),
      .RST_VAL(3'b100)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({bus_en_n, bus_clk, bus_dat}),
      .q    (bus_s)
   );

   scp_shift #(
      .WIDTH(FRAME_W)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .bclk_s  (bus_s[1]),
      .bdat_s  (bus_s[0]),
      .ben_n_s (bus_s[2]),
      .frame   (frame),
      .load_stb(load_stb)
   );

   assign load_chan    = load_stb & ~frame[ADDR_POS];
   assign load_trim    = load_stb &  frame[ADDR_POS];
   assign chan_d       = chan_word_t'({frame[FRAME_W-1:SPARE_POS+1], frame[SPARE_POS-1:1]});
   assign trim_d       = trim_word_t'(frame[TRIM_W:1]);
   assign unused_spare = frame[SPARE_POS];

   scp_bank #(.W(CHAN_W)) u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .retain(retain),
      .load  (load_chan),
      .d     (chan_d),
      .q     (chan_q)
   );

   scp_bank #(.W(TRIM_W)) u_trim (
      .clk   (clk),
      .rst_n (rst_n),
      .retain(retain),
      .load  (load_trim),
      .d     (trim_d),
      .q     (trim_q)
   );

   assign ref_div_sel = chan_q.ref_div_sel;
   assign swallow_cnt = chan_q.swallow_cnt;
   assign main_cnt    = chan_q.main_cnt;
   assign vco_tx_sel  = chan_q.vco_tx_sel;
   assign comp_en     = chan_q.comp_en;
   assign dev_scale   = chan_q.dev_scale;
   assign vco_trim    = chan_q.vco_trim;
   assign cp_step     = chan_q.cp_step;
   assign gauss_en    = chan_q.gauss_en;
   assign pa_level    = trim_q.pa_level;
   assign aux_dac     = trim_q.aux_dac;
   assign comp_scale  = trim_q.comp_scale;
   assign test_sel    = trim_q.test_sel;

endmodule

// File: rtl/scp_checker.sv
module scp_checker
   import scp_pkg::*;
(
   input logic               clk,
   input logic               rst_n,
   input logic               load_stb,
   input logic [FRAME_W-1:0] frame,
   input chan_word_t         chan_q,
   input trim_word_t         trim_q
);

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !load_stb) |=> ($stable(chan_q) && $stable(trim_q)))
      else $error("R3: bank changed without a load strobe");

   p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |=> !load_stb)
      else $error("R3: load strobe lasted more than one cycle");

   p_keep_trim_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load_stb && !frame[0]) |=> $stable(trim_q))
      else $error("R2: trim bank changed on a channel load");

   p_keep_chan_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load_stb && frame[0]) |=> $stable(chan_q))
      else $error("R2: channel bank changed on a trim load");

   p_chan_layout_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (load_stb && !frame[0]) |=>
         (chan_q.swallow_cnt == $past(frame[21:17]) &&
          chan_q.vco_tx_sel  == $past(frame[13]) &&
          chan_q.gauss_en    == $past(frame[1])))
      else $error("R6: channel field taken from the wrong frame bits");

   p_trim_layout_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (load_stb && frame[0]) |=>
         (trim_q.pa_level == $past(frame[13:12]) &&
          trim_q.test_sel == $past(frame[3:1])))
      else $error("R7: trim field taken from the wrong frame bits");

endmodule

bind serial_ctl_port scp_checker u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .load_stb(load_stb),
   .frame   (frame),
   .chan_q  (chan_q),
   .trim_q  (trim_q)
);

// File: tb/tb_serial_ctl_port.sv
module tb_serial_ctl_port;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic retain = 1'b0;
   logic bus_clk = 1'b0;
   logic bus_dat = 1'b0;
   logic bus_en_n = 1'b1;

   logic [1:0] ref_div_sel;
   logic [4:0] swallow_cnt;
   logic [2:0] main_cnt;
   logic       vco_tx_sel;
   logic       comp_en;
   logic [2:0] dev_scale;
   logic [3:0] vco_trim;
   logic [1:0] cp_step;
   logic       gauss_en;
   logic [1:0] pa_level;
   logic [4:0] aux_dac;
   logic [2:0] comp_scale;
   logic [2:0] test_sel;

   int n_checks = 0;
   int n_fail = 0;
   logic done = 1'b0;

   logic [23:0] m_frame = '0;
   logic [21:0] exp_chan = '0;
   logic [12:0] exp_trim = '0;

   always #5 clk = ~clk;

   serial_ctl_port dut (
      .clk(clk), .rst_n(rst_n), .retain(retain),
      .bus_clk(bus_clk), .bus_dat(bus_dat), .bus_en_n(bus_en_n),
      .ref_div_sel(ref_div_sel), .swallow_cnt(swallow_cnt), .main_cnt(main_cnt),
      .vco_tx_sel(vco_tx_sel), .comp_en(comp_en), .dev_scale(dev_scale),
      .vco_trim(vco_trim), .cp_step(cp_step), .gauss_en(gauss_en),
      .pa_level(pa_level), .aux_dac(aux_dac), .comp_scale(comp_scale),
      .test_sel(test_sel)
   );

   function automatic logic [21:0] act_chan();
      return {ref_div_sel, swallow_cnt, main_cnt, vco_tx_sel, comp_en,
              dev_scale, vco_trim, cp_step, gauss_en};
   endfunction

   function automatic logic [12:0] act_trim();
      return {pa_level, aux_dac, comp_scale, test_sel};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic begin_xfer();
      idle(2);
      bus_en_n = 1'b0;
      idle(3);
   endtask

   task automatic shift_bit(input logic b);
      bus_dat = b;
      idle(3);
      bus_clk = 1'b1;
      idle(3);
      bus_clk = 1'b0;
      m_frame = {m_frame[22:0], b};
   endtask

   // Bus model of R2, R5, R6, R7: the frame's last bit picks the bank.
   task automatic end_xfer();
      idle(3);
      bus_en_n = 1'b1;
      if (m_frame[0]) exp_trim = m_frame[13:1];
      else            exp_chan = {m_frame[23:13], m_frame[11:1]};
      idle(6);
   endtask

   task automatic send(input logic [63:0] bits, input int n);
      begin_xfer();
      for (int i = n - 1; i >= 0; i--) shift_bit(bits[i]);
      end_xfer();
   endtask

   task automatic do_reset(input logic keep);
      retain = keep;
      rst_n = 1'b0;
      idle(4);
      rst_n = 1'b1;
      m_frame = '0;
      if (!keep) begin
         exp_chan = '0;
         exp_trim = '0;
      end
      idle(3);
   endtask

   function automatic logic [23:0] chan_frame(
      input logic [1:0] rs, input logic [4:0] sw, input logic [2:0] mc,
      input logic vs, input logic spare, input logic ce, input logic [2:0] dv,
      input logic [3:0] tr, input logic [1:0] cp, input logic ge);
      return {rs, sw, mc, vs, spare, ce, dv, tr, cp, ge, 1'b0};
   endfunction

   task automatic t_reset_state();
      do_reset(1'b0);
      chk("R8 reset clears channel", 32'(act_chan()), 32'd0);
      chk("R8 reset clears trim", 32'(act_trim()), 32'd0);
   endtask

   task automatic t_chan_fields();
      send(64'(chan_frame(2'b10, 5'd27, 3'd4, 1'b1, 1'b1, 1'b1, 3'd5, 4'hA, 2'b01, 1'b1)), 24);
      chk("R6 ref_div_sel", 32'(ref_div_sel), 32'h2);
      chk("R6 swallow_cnt", 32'(swallow_cnt), 32'd27);
      chk("R6 main_cnt", 32'(main_cnt), 32'd4);
      chk("R6 vco_tx_sel", 32'(vco_tx_sel), 32'd1);
      chk("R6 comp_en", 32'(comp_en), 32'd1);
      chk("R6 dev_scale", 32'(dev_scale), 32'd5);
      chk("R6 vco_trim", 32'(vco_trim), 32'hA);
      chk("R6 cp_step", 32'(cp_step), 32'd1);
      chk("R1 MSB-first gauss_en", 32'(gauss_en), 32'd1);
      chk("R2 trim untouched by channel load", 32'(act_trim()), 32'd0);
   endtask

   task automatic t_trim_midway();
      logic [23:0] f;
      logic [21:0] before_c;
      logic [12:0] before_t;
      f = {10'h3FF, 2'b10, 5'd19, 3'd6, 3'd3, 1'b1};
      before_c = act_chan();
      before_t = act_trim();
      begin_xfer();
      for (int i = 23; i >= 12; i--) shift_bit(f[i]);
      chk("R3 channel held mid-transfer", 32'(act_chan()), 32'(before_c));
      chk("R3 trim held mid-transfer", 32'(act_trim()), 32'(before_t));
      for (int i = 11; i >= 0; i--) shift_bit(f[i]);
      end_xfer();
      chk("R7 pa_level", 32'(pa_level), 32'h2);
      chk("R7 aux_dac", 32'(aux_dac), 32'd19);
      chk("R7 comp_scale", 32'(comp_scale), 32'd6);
      chk("R7 test_sel", 32'(test_sel), 32'd3);
      chk("R2 channel untouched by trim load", 32'(act_chan()), 32'(before_c));
   endtask

   task automatic t_long_xfer();
      logic [63:0] bits;
      bits = {34'd0, 6'b111111,
              chan_frame(2'b01, 5'd3, 3'd2, 1'b0, 1'b0, 1'b0, 3'd1, 4'h5, 2'b10, 1'b0)};
      send(bits, 30);
      chk("R4 extra leading bits dropped", 32'(act_chan()),
          32'({2'b01, 5'd3, 3'd2, 1'b0, 1'b0, 3'd1, 4'h5, 2'b10, 1'b0}));
      chk("R4 model agrees", 32'(act_chan()), 32'(exp_chan));
   endtask

   task automatic t_short_xfer();
      send(64'hB5, 8);
      chk("R5 short transfer bank chan", 32'(act_chan()), 32'(exp_chan));
      chk("R5 short transfer bank trim", 32'(act_trim()), 32'(exp_trim));
   endtask

   task automatic t_idle_clocks();
      logic [21:0] c0;
      logic [12:0] t0;
      c0 = act_chan();
      t0 = act_trim();
      for (int i = 0; i < 5; i++) begin
         bus_dat = 1'b1;
         idle(3);
         bus_clk = 1'b1;
         idle(3);
         bus_clk = 1'b0;
      end
      idle(6);
      chk("R1 idle clocks leave channel", 32'(act_chan()), 32'(c0));
      chk("R1 idle clocks leave trim", 32'(act_trim()), 32'(t0));
      send(64'h1, 1);
      chk("R1 idle clocks shifted nothing", 32'(act_trim()), 32'(exp_trim));
      chk("R2 one-bit trim load keeps channel", 32'(act_chan()), 32'(c0));
   endtask

   task automatic t_retain();
      send(64'(chan_frame(2'b11, 5'd9, 3'd7, 1'b1, 1'b0, 1'b0, 3'd2, 4'h3, 2'b11, 1'b1)), 24);
      do_reset(1'b1);
      chk("R8 retain keeps channel", 32'(act_chan()), 32'(exp_chan));
      chk("R8 retain keeps trim", 32'(act_trim()), 32'(exp_trim));
      send(64'h1, 1);
      chk("R8 shift register cleared by reset", 32'(act_trim()), 32'(exp_trim));
      do_reset(1'b0);
      chk("R8 plain reset clears channel", 32'(act_chan()), 32'd0);
      chk("R8 plain reset clears trim", 32'(act_trim()), 32'd0);
   endtask

   initial begin
      t_reset_state();
      t_chan_fields();
      t_trim_midway();
      t_long_xfer();
      t_short_xfer();
      t_idle_clocks();
      t_retain();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

endmodule